// File: doc/BRIEF.md
# Partition Cut-Count Fitness Evaluator

This block scores a whole population of two-way partitioning candidates. A candidate (chromosome) carries one bit per circuit cell, saying which of two partitions the cell sits in. A net is described by a mask with a 1 for every cell it touches. Both are held as sequences of equal-width words in external memories. For each chromosome the block walks all nets word by word and decides whether the net has connected cells on both sides. It then writes the number of nets that are not cut into fitness memory.

A controller starts a run with a one-cycle `start` pulse. The population size, the chromosome length in words, the net count and a bank select are captured at that moment. The block reads chromosome words from the selected half of chromosome memory and net words from netlist memory, and writes one fitness value per chromosome into the same half of fitness memory. It reports the end of the run with a one-cycle `done` pulse. As soon as a net is shown to be cut, the block abandons it and moves on to the next net, so nets cut in an early word cost few reads.

The controller is a state machine with six states. IDLE waits for `start` and goes to CHROM, or straight to DONE when the population is empty. CHROM clears the cut tally and the net and word indices, then goes to ISSUE, or straight to WRITE when the net count is zero. ISSUE drives one read to both memories and goes to EVAL. EVAL folds the returned word pair into the net's two side flags, then:
- goes to WRITE when the net is finished (cut or last word) and it was the last net;
- goes back to ISSUE for the next net when the net is finished and more nets remain;
- goes back to ISSUE for the next word otherwise.

WRITE stores the fitness and goes to CHROM, or to DONE after the last chromosome. DONE pulses `done` and returns to IDLE.

Top module: `cutfit_eval`

## Requirements
- R1: After reset, and for as long as no `start` arrives, `done`, `chrom_re`, `net_re` and `fit_we` stay low.
- R2: Chromosome word w of chromosome c in bank b is read at `chrom_addr` = {b, c, w}, and word w of net n at `net_addr` = {n, w}. Bit i of word w stands for cell w*WORD_W+i. A chromosome bit of 1 puts the cell in partition 1 and 0 puts it in partition 0. A net mask bit of 1 marks a connected cell. Both reads of a word are issued in the same cycle.
- R3: A net is cut exactly when, over all of its words, at least one connected cell lies in partition 1 and at least one connected cell lies in partition 0. The two cells may sit in different words. A net with no connected cells, or with all of them on one side, is not cut.
- R4: Each chromosome c receives exactly one fitness write, at `fit_addr` = {bank_sel, c}, with `fit_wdata` = net count minus the number of cut nets. The writes go in increasing order of c.
- R5: Once a net is proven cut, no further word of that net is read. A net that is not cut is read for all `chrom_words` words. No read addresses a word index at or beyond `chrom_words`, or a net index at or beyond `net_count`.
- R6: `done` is a single-cycle pulse in the cycle after the last fitness write. In the cycle after it there is no read and no write.
- R7: A `start` pulse that arrives while a run is in progress is ignored.
- R8: With `net_count` = 0, every chromosome is written with fitness 0 and no memory is read. With `pop_size` = 0, `done` pulses with no write at all.
- R9: The cut tally is cleared for each chromosome, so a chromosome's fitness does not depend on the chromosomes scored before it.
- R10: Memory read data is taken from `chrom_rdata` and `net_rdata` in the cycle after the read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request, taken only when idle |
| bank_sel | input | 1 | Half of chromosome and fitness memory to use |
| pop_size | input | POP_W | Number of chromosomes to score |
| chrom_words | input | LEN_W | Words per chromosome and per net (at least 1) |
| net_count | input | NET_W | Number of nets |
| chrom_re | output | 1 | Chromosome memory read enable |
| chrom_addr | output | 1+POP_W+LEN_W | Chromosome memory read address |
| chrom_rdata | input | WORD_W | Chromosome word, valid one cycle after the read |
| net_re | output | 1 | Netlist memory read enable |
| net_addr | output | NET_W+LEN_W | Netlist memory read address |
| net_rdata | input | WORD_W | Net mask word, valid one cycle after the read |
| fit_we | output | 1 | Fitness memory write enable |
| fit_addr | output | 1+POP_W | Fitness memory write address |
| fit_wdata | output | NET_W | Fitness value (uncut net count) |
| done | output | 1 | End-of-run pulse |

## Verification
The bench aims at nets whose two sides show up in different words. A design that judged each word on its own would miss those cuts and report too high a fitness. It counts memory reads against a model of early exit. A design that kept reading after a cut, or that stopped too soon on a single-sided net, shows the wrong read total and, in the second case, a wrong fitness. It runs a chromosome where every net is cut followed by one where none is, which exposes a tally that is not cleared. It also covers empty nets, zero nets, an empty population, the upper bank and a second `start` mid-run, where a design that restarted would write chromosomes twice or out of order.

// File: rtl/cutfit_pkg.sv
package cutfit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHROM,
        ST_ISSUE,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } cf_state_t;

endpackage

// File: rtl/cutfit_flags.sv
// Sticky per-net side flags: one for a connected cell in partition 1,
// one for a connected cell in partition 0.
module cutfit_flags #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [WORD_W-1:0] cword,
    input  logic [WORD_W-1:0] nword,
    output logic              side1_nx,
    output logic              side0_nx
);
    logic side1_q;
    logic side0_q;

    always_comb begin
        side1_nx = side1_q | (|(cword & nword));
        side0_nx = side0_q | (|(~cword & nword));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            side1_q <= 1'b0;
            side0_q <= 1'b0;
        end else if (clr) begin
            side1_q <= 1'b0;
            side0_q <= 1'b0;
        end else if (upd) begin
            side1_q <= side1_nx;
            side0_q <= side0_nx;
        end
    end
endmodule

// File: rtl/cutfit_tally.sv
// Cut counter for one chromosome; fitness is the net total minus cuts.
module cutfit_tally #(
    parameter int NET_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [NET_W-1:0] total,
    output logic [NET_W-1:0] fitness
);
    localparam logic [NET_W-1:0] CNT_ONE = NET_W'(1);

    logic [NET_W-1:0] cuts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cuts_q <= '0;
        else if (clr)
            cuts_q <= '0;
        else if (inc)
            cuts_q <= cuts_q + CNT_ONE;
    end

    assign fitness = total - cuts_q;
endmodule

// File: rtl/cutfit_eval.sv
module cutfit_eval
    import cutfit_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int POP_W  = 4,
    parameter int LEN_W  = 3,
    parameter int NET_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     bank_sel,
    input  logic [POP_W-1:0]         pop_size,
    input  logic [LEN_W-1:0]         chrom_words,
    input  logic [NET_W-1:0]         net_count,
    output logic                     chrom_re,
    output logic [POP_W+LEN_W:0]     chrom_addr,
    input  logic [WORD_W-1:0]        chrom_rdata,
    output logic                     net_re,
    output logic [NET_W+LEN_W-1:0]   net_addr,
    input  logic [WORD_W-1:0]        net_rdata,
    output logic                     fit_we,
    output logic [POP_W:0]           fit_addr,
    output logic [NET_W-1:0]         fit_wdata,
    output logic                     done
);
    localparam logic [POP_W-1:0] POP_ONE = POP_W'(1);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [NET_W-1:0] NET_ONE = NET_W'(1);

    cf_state_t state_q, state_d;

    logic             bank_q;
    logic [POP_W-1:0] pop_q, chrom_q;
    logic [LEN_W-1:0] len_q, word_q;
    logic [NET_W-1:0] nets_q, net_q;

    logic side1_nx, side0_nx, cut_now;
    logic last_word, last_net, last_chrom, net_end;
    logic flag_clr, flag_upd, tally_clr, tally_inc;

    assign cut_now    = side1_nx & side0_nx;
    assign last_word  = (word_q == len_q - LEN_ONE);
    assign last_net   = (net_q == nets_q - NET_ONE);
    assign last_chrom = (chrom_q == pop_q - POP_ONE);
    assign net_end    = cut_now | last_word;

    cutfit_flags #(.WORD_W(WORD_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flag_clr),
        .upd      (flag_upd),
        .cword    (chrom_rdata),
        .nword    (net_rdata),
        .side1_nx (side1_nx),
        .side0_nx (side0_nx)
    );

    cutfit_tally #(.NET_W(NET_W)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tally_clr),
        .inc     (tally_inc),
        .total   (nets_q),
        .fitness (fit_wdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = (pop_size == '0) ? ST_DONE : ST_CHROM;
            ST_CHROM: state_d = (nets_q == '0) ? ST_WRITE : ST_ISSUE;
            ST_ISSUE: state_d = ST_EVAL;
            ST_EVAL:  state_d = (net_end && last_net) ? ST_WRITE : ST_ISSUE;
            ST_WRITE: state_d = last_chrom ? ST_DONE : ST_CHROM;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        chrom_re   = (state_q == ST_ISSUE);
        net_re     = (state_q == ST_ISSUE);
        fit_we     = (state_q == ST_WRITE);
        done       = (state_q == ST_DONE);
        flag_upd   = (state_q == ST_EVAL);
        flag_clr   = (state_q == ST_CHROM) || ((state_q == ST_EVAL) && net_end);
        tally_clr  = (state_q == ST_CHROM);
        tally_inc  = (state_q == ST_EVAL) && cut_now;
        chrom_addr = {bank_q, chrom_q, word_q};
        net_addr   = {net_q, word_q};
        fit_addr   = {bank_q, chrom_q};
    end

    // Indices and captured run settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q  <= 1'b0;
            pop_q   <= '0;
            len_q   <= '0;
            nets_q  <= '0;
            chrom_q <= '0;
            net_q   <= '0;
            word_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    bank_q  <= bank_sel;
                    pop_q   <= pop_size;
                    len_q   <= chrom_words;
                    nets_q  <= net_count;
                    chrom_q <= '0;
                end
                ST_CHROM: begin
                    net_q  <= '0;
                    word_q <= '0;
                end
                ST_EVAL: begin
                    if (net_end) begin
                        word_q <= '0;
                        net_q  <= net_q + NET_ONE;
                    end else begin
                        word_q <= word_q + LEN_ONE;
                    end
                end
                ST_WRITE: chrom_q <= chrom_q + POP_ONE;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cutfit_chk.sv
module cutfit_chk #(
    parameter int WORD_W = 8,
    parameter int POP_W  = 4,
    parameter int LEN_W  = 3,
    parameter int NET_W  = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bank_sel,
    input logic [POP_W-1:0]       pop_size,
    input logic [LEN_W-1:0]       chrom_words,
    input logic [NET_W-1:0]       net_count,
    input logic                   chrom_re,
    input logic [POP_W+LEN_W:0]   chrom_addr,
    input logic                   net_re,
    input logic [NET_W+LEN_W-1:0] net_addr,
    input logic                   fit_we,
    input logic [POP_W:0]         fit_addr,
    input logic [NET_W-1:0]       fit_wdata,
    input logic                   done
);
    localparam int CA_W = 1 + POP_W + LEN_W;
    localparam int NA_W = NET_W + LEN_W;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!chrom_re && !net_re && !fit_we));

    // R6
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chrom_re, fit_we, done}));

    // R4
    fit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fit_we |-> (fit_wdata <= net_count));

    // R4
    fit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fit_we |-> (fit_addr[POP_W] == bank_sel && fit_addr[POP_W-1:0] < pop_size));

    // R5
    word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chrom_re |-> (chrom_addr[LEN_W-1:0] < chrom_words));

    // R5
    net_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chrom_re |-> (net_addr[NA_W-1:LEN_W] < net_count));

    // R2
    read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chrom_re |-> (net_re && net_addr[LEN_W-1:0] == chrom_addr[LEN_W-1:0]
                      && chrom_addr[CA_W-1] == bank_sel));

    // R10
    read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chrom_re |=> !chrom_re);
endmodule

bind cutfit_eval cutfit_chk #(
    .WORD_W (WORD_W),
    .POP_W  (POP_W),
    .LEN_W  (LEN_W),
    .NET_W  (NET_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_sel    (bank_sel),
    .pop_size    (pop_size),
    .chrom_words (chrom_words),
    .net_count   (net_count),
    .chrom_re    (chrom_re),
    .chrom_addr  (chrom_addr),
    .net_re      (net_re),
    .net_addr    (net_addr),
    .fit_we      (fit_we),
    .fit_addr    (fit_addr),
    .fit_wdata   (fit_wdata),
    .done        (done)
);

// File: tb/sim_cutfit_eval.sv
`timescale 1ns/1ps
module sim_cutfit_eval;
    localparam int WORD_W = 8;
    localparam int POP_W  = 4;
    localparam int LEN_W  = 3;
    localparam int NET_W  = 5;
    localparam int CA_W   = 1 + POP_W + LEN_W;
    localparam int NA_W   = NET_W + LEN_W;
    localparam int FA_N   = 1 << (POP_W + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bank_sel = 1'b0;
    logic [POP_W-1:0] pop_size = '0;
    logic [LEN_W-1:0] chrom_words = '0;
    logic [NET_W-1:0] net_count = '0;
    logic chrom_re, net_re, fit_we, done;
    logic [CA_W-1:0] chrom_addr;
    logic [NA_W-1:0] net_addr;
    logic [POP_W:0] fit_addr;
    logic [NET_W-1:0] fit_wdata;
    logic [WORD_W-1:0] chrom_rdata = '0;
    logic [WORD_W-1:0] net_rdata = '0;

    always #4 clk = ~clk;

    cutfit_eval #(.WORD_W(WORD_W), .POP_W(POP_W), .LEN_W(LEN_W), .NET_W(NET_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .bank_sel(bank_sel),
        .pop_size(pop_size), .chrom_words(chrom_words), .net_count(net_count),
        .chrom_re(chrom_re), .chrom_addr(chrom_addr), .chrom_rdata(chrom_rdata),
        .net_re(net_re), .net_addr(net_addr), .net_rdata(net_rdata),
        .fit_we(fit_we), .fit_addr(fit_addr), .fit_wdata(fit_wdata), .done(done)
    );

    logic [WORD_W-1:0] cmem [0:(1<<CA_W)-1];
    logic [WORD_W-1:0] nmem [0:(1<<NA_W)-1];
    int fit_got [0:FA_N-1];
    int fit_run [0:FA_N-1];
    int fit_seq [0:FA_N-1];

    int n_cmp = 0, n_bad = 0;
    int run_id = 0;
    int cyc = 0, rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
    int done_cyc = 0, last_wr_cyc = 0;

    // R10: memory models return data the cycle after the read enable
    always @(posedge clk) begin
        if (chrom_re) chrom_rdata <= cmem[chrom_addr];
        if (net_re)   net_rdata   <= nmem[net_addr];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (chrom_re) rd_cnt <= rd_cnt + 1;
        if (fit_we) begin
            fit_got[fit_addr] <= int'(fit_wdata);
            fit_run[fit_addr] <= run_id;
            fit_seq[fit_addr] <= wr_cnt;
            wr_cnt <= wr_cnt + 1;
            last_wr_cyc <= cyc;
        end
        if (done) begin
            done_cnt <= done_cnt + 1;
            done_cyc <= cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int cidx(int b, int c, int w);
        return (b << (POP_W + LEN_W)) | (c << LEN_W) | w;
    endfunction

    function automatic int nidx(int n, int w);
        return (n << LEN_W) | w;
    endfunction

    // Expected fitness and read count for one chromosome (R3, R5)
    function automatic int exp_fit(int b, int c, int len, int nets, output int reads);
        int cuts = 0;
        reads = 0;
        for (int n = 0; n < nets; n++) begin
            bit s1 = 0, s0 = 0;
            for (int w = 0; w < len; w++) begin
                logic [WORD_W-1:0] cw = cmem[cidx(b, c, w)];
                logic [WORD_W-1:0] nw = nmem[nidx(n, w)];
                reads++;
                if ((cw & nw) != '0) s1 = 1;
                if ((~cw & nw) != '0) s0 = 1;
                if (s1 && s0) begin
                    cuts++;
                    break;
                end
            end
        end
        return nets - cuts;
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < (1<<CA_W); i++) cmem[i] = '0;
        for (int i = 0; i < (1<<NA_W); i++) nmem[i] = '0;
    endtask

    function automatic logic [WORD_W-1:0] cell_mask(int w, int cells);
        logic [WORD_W-1:0] m = '0;
        for (int i = 0; i < WORD_W; i++)
            if (w * WORD_W + i < cells) m[i] = 1'b1;
        return m;
    endfunction

    task automatic fill_rand(int b, int pop, int len, int nets);
        int cells = len * WORD_W - int'($urandom_range(0, WORD_W - 1));
        for (int c = 0; c < pop; c++)
            for (int w = 0; w < len; w++)
                cmem[cidx(b, c, w)] = WORD_W'($urandom) & cell_mask(w, cells);
        for (int n = 0; n < nets; n++) begin
            int dens = int'($urandom_range(0, 2));
            for (int w = 0; w < len; w++) begin
                logic [WORD_W-1:0] m = WORD_W'($urandom);
                for (int k = 0; k < dens; k++) m = m & WORD_W'($urandom);
                if ($urandom_range(0, 3) == 0) m = '0;
                nmem[nidx(n, w)] = m & cell_mask(w, cells);
            end
        end
    endtask

    task automatic run_case(input string name, input int pop, input int len,
                            input int nets, input int b, input bit reinject);
        int base_rd, base_wr, base_done, t, exp_reads, r;
        @(negedge clk);
        run_id++;
        bank_sel    = b[0];
        pop_size    = POP_W'(pop);
        chrom_words = LEN_W'(len);
        net_count   = NET_W'(nets);
        base_rd   = rd_cnt;
        base_wr   = wr_cnt;
        base_done = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (reinject) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == base_done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (done_cnt == base_done) begin
            chk(0, "R6", {name, " watchdog, no done"}, t, 0);
            return;
        end
        repeat (4) @(negedge clk);
        // R6 / R7: exactly one done pulse per run
        chk(done_cnt - base_done == 1, reinject ? "R7" : "R6",
            {name, " done pulses"}, done_cnt - base_done, 1);
        // R4 / R8: one write per chromosome
        chk(wr_cnt - base_wr == pop, pop == 0 ? "R8" : "R4",
            {name, " write count"}, wr_cnt - base_wr, pop);
        if (pop > 0)
            chk(done_cyc == last_wr_cyc + 1, "R6", {name, " done after last write"},
                done_cyc - last_wr_cyc, 1);
        exp_reads = 0;
        for (int c = 0; c < pop; c++) begin
            int a = (b << POP_W) | c;
            int e = exp_fit(b, c, len, nets, r);
            exp_reads += r;
            chk(fit_run[a] == run_id && fit_seq[a] == base_wr + c, "R4",
                {name, " write slot/order"}, fit_seq[a] - base_wr, c);
            chk(fit_got[a] == e, "R3", {name, " fitness"}, fit_got[a], e);
        end
        chk(rd_cnt - base_rd == exp_reads, nets == 0 ? "R8" : "R5",
            {name, " read count"}, rd_cnt - base_rd, exp_reads);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int junk;
        void'($urandom(32'h5EED_C0DE));
        for (int i = 0; i < FA_N; i++) begin
            fit_got[i] = -1;
            fit_run[i] = 0;
            fit_seq[i] = -1;
        end
        clear_mem();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !chrom_re && !net_re && !fit_we, "R1", "outputs in reset",
            int'({done, chrom_re, fit_we}), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(rd_cnt == 0 && wr_cnt == 0 && done_cnt == 0, "R1", "idle without start",
            rd_cnt + wr_cnt + done_cnt, 0);

        // Directed: cut across words, single-cell net, early cut, empty net
        clear_mem();
        cmem[cidx(0, 0, 0)] = 8'h01;
        cmem[cidx(0, 1, 0)] = 8'hFF;
        cmem[cidx(0, 1, 1)] = 8'hFF;
        cmem[cidx(0, 1, 2)] = 8'hFF;
        nmem[nidx(0, 0)] = 8'h01;
        nmem[nidx(1, 0)] = 8'h01;
        nmem[nidx(1, 2)] = 8'h80;
        nmem[nidx(2, 0)] = 8'h03;
        run_case("span", 2, 3, 4, 0, 0);
        chk(fit_got[0] == 2, "R3", "cross-word cut fitness", fit_got[0], 2);
        chk(fit_got[1] == 4, "R10", "one-sided chromosome fitness", fit_got[1], 4);
        junk = exp_fit(0, 0, 3, 4, junk);
        chk(junk == 2, "R2", "bench model agrees", junk, 2);

        // R9: fully cut chromosome followed by an uncut one
        clear_mem();
        for (int n = 0; n < 6; n++) nmem[nidx(n, 0)] = 8'h03;
        cmem[cidx(1, 0, 0)] = 8'h55;
        cmem[cidx(1, 0, 1)] = 8'h55;
        cmem[cidx(1, 1, 0)] = 8'hFF;
        cmem[cidx(1, 1, 1)] = 8'hFF;
        run_case("allcut", 2, 2, 6, 1, 0);
        chk(fit_got[(1 << POP_W) | 0] == 0, "R5", "all nets cut", fit_got[1 << POP_W], 0);
        chk(fit_got[(1 << POP_W) | 1] == 6, "R9", "tally cleared per chromosome",
            fit_got[(1 << POP_W) | 1], 6);

        // R8: no nets, then empty population
        fill_rand(0, 3, 2, 0);
        run_case("nonets", 3, 2, 0, 0, 0);
        run_case("nopop", 0, 2, 4, 0, 0);

        // R7: second start during a run, upper bank
        fill_rand(1, 5, 4, 9);
        run_case("restart", 5, 4, 9, 1, 1);

        // Longest words and nets
        fill_rand(0, 4, 7, 31);
        run_case("widest", 4, 7, 31, 0, 0);

        // Constrained random runs
        for (int k = 0; k < 8; k++) begin
            int b    = int'($urandom_range(0, 1));
            int pop  = int'($urandom_range(1, 15));
            int len  = int'($urandom_range(1, 7));
            int nets = int'($urandom_range(1, 31));
            clear_mem();
            fill_rand(b, pop, len, nets);
            run_case($sformatf("rand%0d", k), pop, len, nets, b, 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule